// File: doc/BRIEF.md
# Watermark Flow Control Controller

This block decides when the receive path should ask its link partner to stop sending and when to let it resume. It compares the fill level of a receive data FIFO, counted in 64-byte units, against two programmable watermarks. In full duplex it raises a pause-frame request for the transmit side. In half duplex it drives a jam signal that forces collisions on arriving frames. Building the frame, the MAC datapath and the FIFO storage sit outside the block.

Software writes one 24-bit configuration word. The upper watermark starts a pause. The lower watermark ends it, but only after the pause that was started has been acknowledged, so the two levels give hysteresis. A 4-bit code selects the length of each jam burst, and a 4-bit enable field selects which functions are active. A separate pause-time input supplies the time carried by non-zero pause requests. A one-cycle software pause strobe can force a pause request at any moment.

Top module: `fc_watermark_ctrl`

## Requirements
- R1: The FIFO level is the byte count shifted right by 6. In full duplex with enable bit 0 set, while the flow-control state is disarmed and the level is greater than or equal to the high watermark, a pause request is raised one cycle later. Its pause time equals the programmed pause-time input.
- R2: A raised pause request stays high until a one-cycle acknowledge is sampled. Acknowledging a high-watermark request arms the state. While the state is armed, no further high-watermark request is raised, however long the level stays high.
- R3: While the state is armed and the level is strictly below the low watermark, a request with pause time zero is raised. Acknowledging it disarms the state.
- R4: A zero-time request is never raised unless an earlier high-watermark request was acknowledged. A low level seen while disarmed raises nothing.
- R5: In half duplex, a frame-arrival strobe that matches the class criteria while the level is at or above the high watermark raises jam from the next cycle. Jam lasts exactly (code+1)×DUR_BASE cycles, where code is the 4-bit duration field. A matching frame below the high watermark raises no jam.
- R6: A matching frame that arrives while jam is active restarts the full jam period.
- R7: Frame class codes are: 0 unicast, 1 multicast, 2 broadcast, 3 other. Enable bits 1, 2 and 3 allow jamming of classes 0, 1 and 2 respectively. Class 3 and classes whose bit is clear never jam.
- R8: In full duplex, jam stays low whatever the duration code and frame strobes.
- R9: While the transmitter enable is low, both pause_req and jam are low.
- R10: When the enable field is all zero, pause_req and jam are low and the armed state is cleared. As a result, re-enabling with a low FIFO level raises no zero-time request.
- R11: A software pause strobe raises a request carrying the programmed pause time and leaves the armed state unchanged. A strobe that arrives while a request is already pending is ignored.
- R12: Reset clears the configuration word to zero, so the block stays silent until it is configured. The configuration word layout is: bits 7:0 high watermark, 15:8 low watermark, 19:16 duration code, 23:20 enable field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 24 | Configuration word |
| pause_time_cfg | input | PT_W | Pause time for non-zero requests |
| fifo_bytes | input | CNT_W | Receive FIFO byte count |
| full_duplex | input | 1 | 1 = full duplex, 0 = half duplex |
| tx_enable | input | 1 | Transmitter enabled |
| frame_arrive | input | 1 | One-cycle strobe per arriving frame |
| frame_cls | input | 2 | Class of the arriving frame |
| sw_pause | input | 1 | One-cycle software pause strobe |
| pause_ack | input | 1 | One-cycle acknowledge from the transmit side |
| pause_req | output | 1 | Pause frame request |
| pause_time | output | PT_W | Pause time of the pending request |
| jam | output | 1 | Backpressure (jam) output |

## Verification
Two events can land in the same cycle and are exercised together. The first is a software pause strobe in the cycle where the level crosses the high watermark. The bench expects the software request to be served first and the watermark request to follow one cycle after its acknowledge, because the software request leaves the state disarmed. The second is an acknowledge of the high-watermark request in the cycle where the level drops below the low watermark. The bench expects pause_req to be low for one cycle and then a zero-time request to appear. Apart from these cases, the bench sweeps every byte count below the threshold, all sixteen duration codes, and every pairing of enable mask and frame class.

// File: rtl/fc_pkg.sv
`timescale 1ns/1ps
package fc_pkg;

    localparam int THR_W      = 8;
    localparam int UNIT_SHIFT = 6;

    typedef enum logic [1:0] {
        REQ_HI = 2'd0,
        REQ_LO = 2'd1,
        REQ_SW = 2'd2
    } req_kind_e;

    typedef enum logic [1:0] {
        CLS_UNI   = 2'd0,
        CLS_MULTI = 2'd1,
        CLS_BCAST = 2'd2,
        CLS_OTHER = 2'd3
    } frame_cls_e;

    typedef struct packed {
        logic [3:0]       en;
        logic [3:0]       dur;
        logic [THR_W-1:0] lo;
        logic [THR_W-1:0] hi;
    } fc_cfg_t;

    function automatic int unsigned jam_cycles(input logic [3:0] code, input int unsigned base);
        return (32'(code) + 32'd1) * base;
    endfunction

    function automatic logic cls_hit(input logic [3:0] en, input logic [1:0] cls);
        case (frame_cls_e'(cls))
            CLS_UNI:   return en[1];
            CLS_MULTI: return en[2];
            CLS_BCAST: return en[3];
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/fc_cfg_reg.sv
`timescale 1ns/1ps
module fc_cfg_reg
    import fc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [$bits(fc_cfg_t)-1:0] wdata,
    output fc_cfg_t              cfg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (we) begin
            cfg <= fc_cfg_t'(wdata);
        end
    end

    a_r12_cfg_load: assert property (@(posedge clk) disable iff (rst)
        we |=> cfg == fc_cfg_t'($past(wdata)));

endmodule

// File: rtl/fc_level_cmp.sv
`timescale 1ns/1ps
module fc_level_cmp
    import fc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] fifo_bytes,
    input  logic [THR_W-1:0] hi,
    input  logic [THR_W-1:0] lo,
    output logic             at_hi,
    output logic             below_lo
);

    logic [CNT_W-1:0] level;

    always_comb begin
        level    = fifo_bytes >> UNIT_SHIFT;
        at_hi    = level >= CNT_W'(hi);
        below_lo = level <  CNT_W'(lo);
    end

    always_comb begin
        if (lo <= hi) begin
            a_r1_hi_lo_exclusive: assert (!(at_hi && below_lo));
        end
    end

endmodule

// File: rtl/fc_pause_ctrl.sv
`timescale 1ns/1ps
module fc_pause_ctrl
    import fc_pkg::*;
#(
    parameter int PT_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en_any,
    input  logic            tx_on,
    input  logic            auto_en,
    input  logic            at_hi,
    input  logic            below_lo,
    input  logic            sw_pause,
    input  logic            ack,
    input  logic [PT_W-1:0] pt_cfg,
    output logic            pause_req,
    output logic [PT_W-1:0] pause_time
);

    logic      req_v;
    logic      armed;
    req_kind_e kind;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_v <= 1'b0;
            armed <= 1'b0;
            kind  <= REQ_HI;
        end else if (!en_any) begin
            req_v <= 1'b0;
            armed <= 1'b0;
        end else if (!tx_on) begin
            req_v <= 1'b0;
        end else if (req_v) begin
            if (ack) begin
                req_v <= 1'b0;
                if (kind == REQ_HI) armed <= 1'b1;
                if (kind == REQ_LO) armed <= 1'b0;
            end
        end else if (sw_pause) begin
            req_v <= 1'b1;
            kind  <= REQ_SW;
        end else if (auto_en && !armed && at_hi) begin
            req_v <= 1'b1;
            kind  <= REQ_HI;
        end else if (auto_en && armed && below_lo) begin
            req_v <= 1'b1;
            kind  <= REQ_LO;
        end
    end

    always_comb begin
        pause_req  = req_v && tx_on && en_any;
        pause_time = (pause_req && kind != REQ_LO) ? pt_cfg : '0;
    end

    a_r2_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
        req_v && !ack && tx_on && en_any |=> req_v && $stable(kind));

    a_r2_arm_on_hi_ack: assert property (@(posedge clk) disable iff (rst)
        req_v && kind == REQ_HI && ack && tx_on && en_any |=> armed);

    a_r3_disarm_on_lo_ack: assert property (@(posedge clk) disable iff (rst)
        req_v && kind == REQ_LO && ack && tx_on && en_any |=> !armed);

    a_r4_lo_needs_armed: assert property (@(posedge clk) disable iff (rst)
        req_v && kind == REQ_LO |-> armed);

    a_r10_en_off_clears: assert property (@(posedge clk) disable iff (rst)
        !en_any |=> !armed && !req_v);

    a_r11_sw_keeps_armed: assert property (@(posedge clk) disable iff (rst)
        req_v && kind == REQ_SW && ack && tx_on && en_any |=> armed == $past(armed));

endmodule

// File: rtl/fc_jam_timer.sv
`timescale 1ns/1ps
module fc_jam_timer
    import fc_pkg::*;
#(
    parameter int DUR_BASE = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       active,
    input  logic       hit,
    input  logic [3:0] code,
    output logic       jam
);

    localparam int MAX_LEN = 16 * DUR_BASE;
    localparam int CW      = $clog2(MAX_LEN + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            cnt <= '0;
        end else if (hit) begin
            cnt <= CW'(jam_cycles(code, DUR_BASE));
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign jam = (cnt != '0) && active;

    a_r6_reload: assert property (@(posedge clk) disable iff (rst)
        active && hit |=> cnt == CW'(jam_cycles($past(code), DUR_BASE)));

    a_r5_count_down: assert property (@(posedge clk) disable iff (rst)
        active && !hit && cnt != '0 |=> cnt == $past(cnt) - 1'b1 || cnt == '0);

    a_r5_bounded: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(MAX_LEN));

endmodule

// File: rtl/fc_watermark_ctrl.sv
`timescale 1ns/1ps
module fc_watermark_ctrl
    import fc_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int PT_W     = 16,
    parameter int DUR_BASE = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [23:0]      cfg_wdata,
    input  logic [PT_W-1:0]  pause_time_cfg,
    input  logic [CNT_W-1:0] fifo_bytes,
    input  logic             full_duplex,
    input  logic             tx_enable,
    input  logic             frame_arrive,
    input  logic [1:0]       frame_cls,
    input  logic             sw_pause,
    input  logic             pause_ack,
    output logic             pause_req,
    output logic [PT_W-1:0]  pause_time,
    output logic             jam
);

    fc_cfg_t cfg;
    logic    at_hi;
    logic    below_lo;
    logic    en_any;
    logic    jam_active;
    logic    jam_hit;

    fc_cfg_reg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    fc_level_cmp #(.CNT_W(CNT_W)) u_cmp (
        .fifo_bytes (fifo_bytes),
        .hi         (cfg.hi),
        .lo         (cfg.lo),
        .at_hi      (at_hi),
        .below_lo   (below_lo)
    );

    always_comb begin
        en_any     = cfg.en != 4'd0;
        jam_active = en_any && tx_enable && !full_duplex;
        jam_hit    = frame_arrive && at_hi && cls_hit(cfg.en, frame_cls);
    end

    fc_pause_ctrl #(.PT_W(PT_W)) u_pause (
        .clk        (clk),
        .rst        (rst),
        .en_any     (en_any),
        .tx_on      (tx_enable),
        .auto_en    (full_duplex && cfg.en[0]),
        .at_hi      (at_hi),
        .below_lo   (below_lo),
        .sw_pause   (sw_pause),
        .ack        (pause_ack),
        .pt_cfg     (pause_time_cfg),
        .pause_req  (pause_req),
        .pause_time (pause_time)
    );

    fc_jam_timer #(.DUR_BASE(DUR_BASE)) u_jam (
        .clk    (clk),
        .rst    (rst),
        .active (jam_active),
        .hit    (jam_hit),
        .code   (cfg.dur),
        .jam    (jam)
    );

    a_r9_tx_off_quiet: assert property (@(posedge clk) disable iff (rst)
        !tx_enable |-> !pause_req && !jam);

    a_r8_no_jam_full_duplex: assert property (@(posedge clk) disable iff (rst)
        full_duplex |-> !jam);

    a_r10_en_zero_quiet: assert property (@(posedge clk) disable iff (rst)
        cfg.en == 4'd0 |-> !pause_req && !jam);

endmodule

// File: tb/test_fc_watermark_ctrl.sv
`timescale 1ns/1ps
module test_fc_watermark_ctrl;

    localparam int BASE = 2;
    localparam logic [15:0] PT = 16'hABCD;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [23:0] cfg_wdata = '0;
    logic [15:0] pause_time_cfg = PT;
    logic [15:0] fifo_bytes = '0;
    logic        full_duplex = 1'b0;
    logic        tx_enable = 1'b0;
    logic        frame_arrive = 1'b0;
    logic [1:0]  frame_cls = '0;
    logic        sw_pause = 1'b0;
    logic        pause_ack = 1'b0;
    logic        pause_req;
    logic [15:0] pause_time;
    logic        jam;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    fc_watermark_ctrl #(.CNT_W(16), .PT_W(16), .DUR_BASE(BASE)) i_fc_watermark_ctrl (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .pause_time_cfg(pause_time_cfg), .fifo_bytes(fifo_bytes),
        .full_duplex(full_duplex), .tx_enable(tx_enable),
        .frame_arrive(frame_arrive), .frame_cls(frame_cls),
        .sw_pause(sw_pause), .pause_ack(pause_ack),
        .pause_req(pause_req), .pause_time(pause_time), .jam(jam)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_cfg(input logic [7:0] hi, input logic [7:0] lo,
                          input logic [3:0] dur, input logic [3:0] en);
        cfg_we    = 1'b1;
        cfg_wdata = {en, dur, lo, hi};
        cyc(1);
        cfg_we    = 1'b0;
    endtask

    task automatic ack_pulse();
        pause_ack = 1'b1;
        cyc(1);
        pause_ack = 1'b0;
    endtask

    task automatic frame_pulse(input logic [1:0] cls);
        frame_cls    = cls;
        frame_arrive = 1'b1;
        cyc(1);
        frame_arrive = 1'b0;
    endtask

    task automatic count_jam(output int n);
        n = 0;
        while (jam && n < 1000) begin
            n++;
            cyc(1);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int n;
        cyc(3);
        rst = 1'b0;
        cyc(1);
        check("R12 reset pause_req", pause_req, 0);
        check("R12 reset jam", jam, 0);
        check("R12 reset pause_time", pause_time, 0);

        // R12: configuration is zero after reset, so nothing fires
        fifo_bytes = 16'hFFFF; full_duplex = 1'b1; tx_enable = 1'b1;
        cyc(3);
        check("R12 no pause with reset cfg", pause_req, 0);
        full_duplex = 1'b0;
        frame_pulse(2'd0);
        check("R12 no jam with reset cfg", jam, 0);

        fifo_bytes = 0; full_duplex = 1'b1;
        wr_cfg(8'd4, 8'd2, 4'd0, 4'b1111);
        cyc(3);
        check("R4 low level disarmed no request", pause_req, 0);

        // R1: every byte count below 4*64 stays silent
        for (int b = 0; b < 256; b++) begin
            fifo_bytes = 16'(b);
            cyc(1);
            if (pause_req !== 1'b0) check("R1 below high watermark", pause_req, 0);
            else n_cmp++;
        end

        // R9: transmitter off suppresses request
        tx_enable = 1'b0; fifo_bytes = 16'd256;
        cyc(3);
        check("R9 tx off no pause", pause_req, 0);
        tx_enable = 1'b1;
        cyc(1);
        check("R1 request at high watermark", pause_req, 1);
        check("R1 pause time programmed", pause_time, PT);
        cyc(4);
        check("R2 request held without ack", pause_req, 1);
        ack_pulse();
        check("R2 request drops on ack", pause_req, 0);
        for (int b = 256; b < 1024; b += 8) begin
            fifo_bytes = 16'(b);
            cyc(1);
            if (pause_req !== 1'b0) check("R2 single request while high", pause_req, 0);
            else n_cmp++;
        end

        // R3: resume below low watermark
        fifo_bytes = 16'd128;
        cyc(2);
        check("R3 level equal low no resume", pause_req, 0);
        fifo_bytes = 16'd127;
        cyc(1);
        check("R3 resume request", pause_req, 1);
        check("R3 resume time zero", pause_time, 0);
        cyc(2);
        check("R3 resume held", pause_req, 1);
        ack_pulse();
        check("R3 resume drops on ack", pause_req, 0);
        cyc(3);
        check("R4 no second resume when disarmed", pause_req, 0);

        // R11: software pause while disarmed, second strobe while pending ignored
        sw_pause = 1'b1; cyc(1); sw_pause = 1'b0;
        check("R11 software request", pause_req, 1);
        check("R11 software time", pause_time, PT);
        sw_pause = 1'b1; cyc(1); sw_pause = 1'b0;
        ack_pulse();
        check("R11 request drops on ack", pause_req, 0);
        cyc(2);
        check("R11 pending strobe ignored, armed unchanged", pause_req, 0);

        // Same cycle: software strobe and high crossing
        fifo_bytes = 16'd256; sw_pause = 1'b1;
        cyc(1); sw_pause = 1'b0;
        check("R11 software first on crossing", pause_req, 1);
        ack_pulse();
        check("R11 gap after software ack", pause_req, 0);
        cyc(1);
        check("R1 watermark request follows software", pause_req, 1);
        check("R1 watermark time", pause_time, PT);
        ack_pulse();
        cyc(2);
        check("R2 armed no repeat", pause_req, 0);

        // R11: software pause while armed keeps armed
        sw_pause = 1'b1; cyc(1); sw_pause = 1'b0;
        check("R11 software while armed", pause_req, 1);
        ack_pulse();
        fifo_bytes = 16'd64;
        cyc(1);
        check("R11 armed kept, resume follows", pause_req, 1);
        check("R3 resume time zero after sw", pause_time, 0);
        ack_pulse();

        // Same cycle: ack of high request and drop below low
        fifo_bytes = 16'd256;
        cyc(1);
        check("R1 request again", pause_req, 1);
        fifo_bytes = 16'd0;
        ack_pulse();
        check("R2 gap after high ack", pause_req, 0);
        cyc(1);
        check("R3 resume right after ack", pause_req, 1);
        check("R3 resume zero time", pause_time, 0);
        ack_pulse();

        // R10: enable cleared wipes armed state
        fifo_bytes = 16'd256;
        cyc(1);
        ack_pulse();
        fifo_bytes = 16'd0;
        wr_cfg(8'd4, 8'd2, 4'd0, 4'b0000);
        cyc(1);
        check("R10 disabled no request", pause_req, 0);
        wr_cfg(8'd4, 8'd2, 4'd0, 4'b1111);
        cyc(3);
        check("R10 armed cleared, no resume", pause_req, 0);
        fifo_bytes = 16'd256;
        cyc(1);
        check("R10 pending request seen", pause_req, 1);
        wr_cfg(8'd4, 8'd2, 4'd0, 4'b0000);
        check("R10 pending request dropped", pause_req, 0);
        fifo_bytes = 16'd0;

        // Half duplex jam
        full_duplex = 1'b0; fifo_bytes = 16'd256;
        for (int c = 0; c < 16; c++) begin
            wr_cfg(8'd4, 8'd2, 4'(c), 4'b1110);
            frame_pulse(2'd0);
            count_jam(n);
            check($sformatf("R5 jam length code %0d", c), n, (c + 1) * BASE);
        end
        check("R5 no pause in half duplex", pause_req, 0);

        wr_cfg(8'd4, 8'd2, 4'd3, 4'b1110);
        frame_pulse(2'd1);
        cyc(4);
        check("R6 jam still active", jam, 1);
        frame_pulse(2'd1);
        count_jam(n);
        check("R6 jam restarted", n, 4 * BASE);

        fifo_bytes = 16'd255;
        frame_pulse(2'd0);
        check("R5 below high no jam", jam, 0);
        fifo_bytes = 16'd256;

        // R7: enable mask versus class
        for (int e = 0; e < 16; e++) begin
            for (int c = 0; c < 4; c++) begin
                logic exp;
                exp = (c < 3) ? e[c + 1] : 1'b0;
                wr_cfg(8'd4, 8'd2, 4'd0, 4'(e));
                frame_pulse(2'(c));
                if (jam !== exp) check($sformatf("R7 en %0h class %0d", e, c), jam, exp);
                else n_cmp++;
                cyc(3);
            end
        end

        // R8: full duplex ignores duration and never jams
        full_duplex = 1'b1;
        wr_cfg(8'd4, 8'd2, 4'd15, 4'b1110);
        frame_pulse(2'd0);
        check("R8 no jam in full duplex", jam, 0);
        cyc(2);
        check("R8 no jam later", jam, 0);

        // R9: tx off stops jam
        full_duplex = 1'b0;
        tx_enable = 1'b0;
        frame_pulse(2'd0);
        check("R9 tx off no jam", jam, 0);
        tx_enable = 1'b1;
        frame_pulse(2'd0);
        check("R9 jam starts with tx on", jam, 1);
        cyc(2);
        tx_enable = 1'b0;
        cyc(1);
        check("R9 jam cut by tx off", jam, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule